// File: doc/BRIEF.md
# Shot Trailer Word Generator

This block writes a fixed four-word metadata record after the last post-trigger sample of each acquisition shot. When the trigger strobe fires, it takes a snapshot of three values: the running seconds counter, the running coarse tick counter and the word that identifies which trigger source fired. When the end-of-shot strobe arrives, it sends the four record words over a 32-bit valid/ready stream to the memory writer. The memory writer places them directly after the samples of the shot.

The snapshot is taken once per shot. It stays fixed while the shot finishes and while the record drains, however slowly the downstream side accepts words. The counters keep running during this time. A one-cycle done pulse marks the end of each record, so a multi-shot sequencer can start the next shot. An end-of-shot strobe with no trigger before it produces nothing. A trigger and an end-of-shot in the same cycle start a record for a shot with zero post-trigger samples.

Top module: `shot_trailer_gen`

## Requirements
- R1: While reset is held and after it is released, `tvalid_o` and `done_o` are low. No word is offered until a trigger and then an end-of-shot have been seen.
- R2: Word 0 of the record equals bits [31:0] of `sec_i` sampled in the capture cycle.
- R3: Word 1 holds the constant 0xACCE55 in bits [31:8] and bits [39:32] of the captured `sec_i` in bits [7:0].
- R4: Word 2 equals `tick_i` sampled in the capture cycle.
- R5: Word 3 equals `src_i` sampled in the capture cycle.
- R6: Words go out in the order 0, 1, 2, 3, one word per cycle where `tvalid_o` and `tready_i` are both high. While `tready_i` is low, `tvalid_o` stays high and `tdata_o` stays unchanged.
- R7: `done_o` is high for exactly one cycle: the cycle after word 3 is accepted. `tvalid_o` is low in that cycle.
- R8: Only the first `trig_i` after the previous record (or after reset) captures values. Later triggers before the record's `done_o` have no effect, and neither does counter movement. This includes a trigger in the same cycle as the final handshake.
- R9: `eos_i` with no capture pending is ignored, and no word is offered.
- R10: `trig_i` and `eos_i` high together while waiting for a trigger capture the values and start the record. Word 0 is offered in the next cycle.
- R11: Consecutive shots each produce their own record with their own captured values.
- R12: `tvalid_o` rises in the cycle after the accepted `eos_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling-domain clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sec_i | input | 40 | Running seconds counter |
| tick_i | input | 32 | Running coarse tick counter |
| src_i | input | 32 | Latched trigger-source word |
| trig_i | input | 1 | Trigger strobe |
| eos_i | input | 1 | End-of-shot strobe (last post-trigger sample stored) |
| tready_i | input | 1 | Downstream ready |
| tvalid_o | output | 1 | Record word valid |
| tdata_o | output | 32 | Record word |
| done_o | output | 1 | One-cycle pulse after word 3 is accepted |

## Verification
A trigger can arrive in the same cycle that the final record word is handshaken. The design must treat it as belonging to the finished shot and drop it. The bench provokes this by raising `trig_i` with fresh counter values exactly when `tready_i` releases word 3. It then sends an end-of-shot alone, checks that no word appears, and runs one more full shot to confirm that the following record carries only the values from the newer trigger. The same-cycle pairing of trigger and end-of-shot is checked separately: word 0 must appear one cycle later and must carry the values from that cycle.

// File: rtl/trl_pkg.sv
package trl_pkg;
   typedef enum logic [1:0] {
      ST_ARM  = 2'd0,
      ST_HOLD = 2'd1,
      ST_SEND = 2'd2
   } trl_state_e;

   localparam int unsigned TRL_WORDS = 4;
   localparam int unsigned TRL_IDX_W = $clog2(TRL_WORDS);
   localparam logic [23:0] TRL_TAG_DEF = 24'hACCE55;
endpackage

// File: rtl/trl_snap.sv
module trl_snap #(
   parameter int unsigned SEC_W  = 40,
   parameter int unsigned TICK_W = 32,
   parameter int unsigned SRC_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cap_i,
   input  logic [SEC_W-1:0]  sec_i,
   input  logic [TICK_W-1:0] tick_i,
   input  logic [SRC_W-1:0]  src_i,
   output logic [SEC_W-1:0]  sec_q,
   output logic [TICK_W-1:0] tick_q,
   output logic [SRC_W-1:0]  src_q
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sec_q  <= '0;
         tick_q <= '0;
         src_q  <= '0;
      end else if (cap_i) begin
         sec_q  <= sec_i;
         tick_q <= tick_i;
         src_q  <= src_i;
      end
   end

   // R8: without a capture strobe the snapshot must not move
   p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_i |=> ($stable(sec_q) && $stable(tick_q) && $stable(src_q)));
endmodule

// File: rtl/trl_seq.sv
module trl_seq
   import trl_pkg::*;
(
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 trig_i,
   input  logic                 eos_i,
   input  logic                 ready_i,
   output logic                 cap_o,
   output logic                 valid_o,
   output logic [TRL_IDX_W-1:0] idx_o,
   output logic                 done_o
);
   localparam logic [TRL_IDX_W-1:0] LAST_IDX = TRL_IDX_W'(TRL_WORDS - 1);

   trl_state_e st_q, st_d;
   logic [TRL_IDX_W-1:0] idx_q;
   logic fire, last_fire;

   assign cap_o     = (st_q == ST_ARM) && trig_i;
   assign valid_o   = (st_q == ST_SEND);
   assign idx_o     = idx_q;
   assign fire      = valid_o && ready_i;
   assign last_fire = fire && (idx_q == LAST_IDX);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_ARM: begin
            if (trig_i && eos_i) st_d = ST_SEND;
            else if (trig_i)     st_d = ST_HOLD;
         end
         ST_HOLD: if (eos_i)     st_d = ST_SEND;
         ST_SEND: if (last_fire) st_d = ST_ARM;
         default:                st_d = ST_ARM;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= ST_ARM;
         idx_q  <= '0;
         done_o <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_o <= last_fire;
         if (st_q != ST_SEND) idx_q <= '0;
         else if (fire)       idx_q <= idx_q + 1'b1;
      end
   end

   // R6: a stalled word keeps its slot
   p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !ready_i) |=> (valid_o && $stable(idx_o)));
   // R6: an accepted non-final word is followed by the next one
   p_advance_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire && idx_o != LAST_IDX) |=> (valid_o && idx_o == $past(idx_o) + 1'b1));
   // R7: done only right after the final handshake, with the stream idle
   p_done_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && ready_i && idx_o == LAST_IDX) |=> (done_o && !valid_o));
   p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
   // R12: an end-of-shot after a capture opens the stream on the next cycle
   p_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_HOLD && eos_i) |=> (valid_o && idx_o == '0));
endmodule

// File: rtl/trl_fmt.sv
module trl_fmt
   import trl_pkg::*;
#(
   parameter int unsigned SEC_W  = 40,
   parameter int unsigned TICK_W = 32,
   parameter int unsigned SRC_W  = 32,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned TAG_W  = 24,
   parameter logic [TAG_W-1:0] TAG = TAG_W'(TRL_TAG_DEF)
) (
   input  logic [SEC_W-1:0]     sec_q,
   input  logic [TICK_W-1:0]    tick_q,
   input  logic [SRC_W-1:0]     src_q,
   input  logic [TRL_IDX_W-1:0] idx_i,
   output logic [WORD_W-1:0]    word_o
);
   localparam int unsigned HI_W = WORD_W - TAG_W;

   logic [WORD_W-1:0] sec_lo, tick_w, src_w;
   logic [HI_W-1:0]   sec_hi;

   generate
      if (SEC_W > WORD_W) begin : g_split
         localparam int unsigned UP_W = SEC_W - WORD_W;
         always_comb begin
            sec_lo = sec_q[WORD_W-1:0];
            sec_hi = '0;
            sec_hi[UP_W-1:0] = sec_q[SEC_W-1:WORD_W];
         end
      end else begin : g_fit
         always_comb begin
            sec_lo = '0;
            sec_lo[SEC_W-1:0] = sec_q;
            sec_hi = '0;
         end
      end
   endgenerate

   always_comb begin
      tick_w = '0;
      tick_w[TICK_W-1:0] = tick_q;
      src_w = '0;
      src_w[SRC_W-1:0] = src_q;
   end

   always_comb begin
      unique case (idx_i)
         2'd0:    word_o = sec_lo;
         2'd1:    word_o = {TAG, sec_hi};
         2'd2:    word_o = tick_w;
         default: word_o = src_w;
      endcase
   end
endmodule

// File: rtl/shot_trailer_gen.sv
module shot_trailer_gen
   import trl_pkg::*;
#(
   parameter int unsigned SEC_W  = 40,
   parameter int unsigned TICK_W = 32,
   parameter int unsigned SRC_W  = 32,
   parameter int unsigned WORD_W = 32,
   parameter int unsigned TAG_W  = 24,
   parameter logic [TAG_W-1:0] TAG = TAG_W'(TRL_TAG_DEF)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SEC_W-1:0]  sec_i,
   input  logic [TICK_W-1:0] tick_i,
   input  logic [SRC_W-1:0]  src_i,
   input  logic              trig_i,
   input  logic              eos_i,
   input  logic              tready_i,
   output logic              tvalid_o,
   output logic [WORD_W-1:0] tdata_o,
   output logic              done_o
);
   localparam int unsigned HI_W = WORD_W - TAG_W;

   initial begin : g_param_chk
      assert (TAG_W < WORD_W) else $error("tag must leave room for upper seconds");
      assert (SEC_W <= WORD_W + HI_W) else $error("seconds wider than two fields");
      assert (TICK_W <= WORD_W && SRC_W <= WORD_W) else $error("field wider than a word");
      assert (TICK_W > 0 && SRC_W > 0 && SEC_W > 0) else $error("zero-width field");
   end

   logic                 cap;
   logic [TRL_IDX_W-1:0] idx;
   logic [SEC_W-1:0]     sec_q;
   logic [TICK_W-1:0]    tick_q;
   logic [SRC_W-1:0]     src_q;

   trl_seq u_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .trig_i  (trig_i),
      .eos_i   (eos_i),
      .ready_i (tready_i),
      .cap_o   (cap),
      .valid_o (tvalid_o),
      .idx_o   (idx),
      .done_o  (done_o)
   );

   trl_snap #(.SEC_W(SEC_W), .TICK_W(TICK_W), .SRC_W(SRC_W)) u_snap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (cap),
      .sec_i  (sec_i),
      .tick_i (tick_i),
      .src_i  (src_i),
      .sec_q  (sec_q),
      .tick_q (tick_q),
      .src_q  (src_q)
   );

   trl_fmt #(.SEC_W(SEC_W), .TICK_W(TICK_W), .SRC_W(SRC_W),
             .WORD_W(WORD_W), .TAG_W(TAG_W), .TAG(TAG)) u_fmt (
      .sec_q  (sec_q),
      .tick_q (tick_q),
      .src_q  (src_q),
      .idx_i  (idx),
      .word_o (tdata_o)
   );

   // R6: offered data may not change while stalled
   p_stall_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tvalid_o && !tready_i) |=> $stable(tdata_o));
   // R3: the slot after word 0 always carries the tag
   p_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tvalid_o && tready_i && idx == '0) |=> (tdata_o[WORD_W-1:HI_W] == TAG));
   // R1: the stream is quiet when leaving reset
   p_reset_quiet_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (!tvalid_o && !done_o));
endmodule

// File: tb/shot_trailer_gen_tb_top.sv
module shot_trailer_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:0] sec = '0;
   logic [31:0] tick = '0;
   logic [31:0] src = '0;
   logic        trig = 1'b0;
   logic        eos = 1'b0;
   logic        tready = 1'b0;
   logic        tvalid;
   logic [31:0] tdata;
   logic        done;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   shot_trailer_gen dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sec_i(sec), .tick_i(tick), .src_i(src),
      .trig_i(trig), .eos_i(eos), .tready_i(tready),
      .tvalid_o(tvalid), .tdata_o(tdata), .done_o(done)
   );

   // {sec, tick, src, stall cycles per word}
   localparam logic [105:0] VEC [4] = '{
      {40'h12_3456_789A, 32'h0000_1000, 32'h0000_0001, 2'd0},
      {40'hFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0F00, 2'd2},
      {40'h00_0000_0000, 32'h0000_0000, 32'h0000_0002, 2'd1},
      {40'hA5_0000_0001, 32'h8000_0001, 32'h0000_0110, 2'd3}
   };

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_word(input string req, input logic [31:0] exp, input int stall,
                            input bit last, input bit trig_on_last);
      for (int s = 0; s < stall; s++) begin
         tready = 1'b0;
         chk("R6 stall valid", 64'(tvalid), 64'd1);
         chk({req, " R6 stall data"}, 64'(tdata), 64'(exp));
         @(negedge clk);
      end
      tready = 1'b1;
      if (last && trig_on_last) begin
         trig = 1'b1;
         sec = 40'h77_7777_7777;
      end
      chk("R6 valid", 64'(tvalid), 64'd1);
      chk(req, 64'(tdata), 64'(exp));
      @(negedge clk);
      tready = 1'b0;
      trig = 1'b0;
   endtask

   task automatic drain(input logic [39:0] s, input logic [31:0] t, input logic [31:0] w,
                        input int stall, input bit trig_on_last);
      send_word("R2 word0", s[31:0], stall, 1'b0, 1'b0);
      send_word("R3 word1", {24'hACCE55, s[39:32]}, stall, 1'b0, 1'b0);
      send_word("R4 word2", t, stall, 1'b0, 1'b0);
      send_word("R5 word3", w, stall, 1'b1, trig_on_last);
      chk("R7 done high", 64'(done), 64'd1);
      chk("R7 valid low at done", 64'(tvalid), 64'd0);
      @(negedge clk);
      chk("R7 done one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 valid in reset", 64'(tvalid), 64'd0);
      chk("R1 done in reset", 64'(done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", 64'(tvalid), 64'd0);

      // R9: end-of-shot with nothing captured
      eos = 1'b1;
      @(negedge clk);
      eos = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R9 no word", 64'(tvalid), 64'd0);
         @(negedge clk);
      end

      // table of shots: R2..R8, R11, R12
      foreach (VEC[i]) begin
         logic [39:0] vs;
         logic [31:0] vt, vw;
         int          st;
         vs = VEC[i][105:66];
         vt = VEC[i][65:34];
         vw = VEC[i][33:2];
         st = int'(VEC[i][1:0]);
         sec = vs; tick = vt; src = vw; trig = 1'b1;
         @(negedge clk);
         trig = 1'b0;
         sec = vs + 40'd9; tick = vt + 32'd100; src = ~vw;
         @(negedge clk);
         trig = 1'b1;                          // R8: late trigger ignored
         sec = vs ^ 40'hF0; tick = vt ^ 32'h55;
         @(negedge clk);
         trig = 1'b0;
         chk("R8 no early word", 64'(tvalid), 64'd0);
         eos = 1'b1;
         @(negedge clk);
         eos = 1'b0;
         chk("R12 valid after eos", 64'(tvalid), 64'd1);
         drain(vs, vt, vw, st, 1'b0);
      end

      // R10: trigger and end-of-shot in the same cycle
      sec = 40'h3C_CAFE_F00D; tick = 32'h0BAD_BEEF; src = 32'h0000_0800;
      trig = 1'b1; eos = 1'b1;
      @(negedge clk);
      trig = 1'b0; eos = 1'b0; sec = '0; tick = '0; src = '0;
      chk("R10 valid next cycle", 64'(tvalid), 64'd1);
      drain(40'h3C_CAFE_F00D, 32'h0BAD_BEEF, 32'h0000_0800, 0, 1'b0);

      // R8: trigger coinciding with the final handshake is dropped
      sec = 40'h01_0000_0002; tick = 32'h2222_2222; src = 32'h0000_0010;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      eos = 1'b1;
      @(negedge clk);
      eos = 1'b0;
      drain(40'h01_0000_0002, 32'h2222_2222, 32'h0000_0010, 1, 1'b1);
      eos = 1'b1;
      @(negedge clk);
      eos = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk("R8 trigger at last handshake ignored", 64'(tvalid), 64'd0);
         @(negedge clk);
      end

      // R11: next shot still captures fresh values
      sec = 40'h0E_1234_0000; tick = 32'h0000_0042; src = 32'h0000_0200;
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0; tick = 32'h9999_9999;
      eos = 1'b1;
      @(negedge clk);
      eos = 1'b0;
      drain(40'h0E_1234_0000, 32'h0000_0042, 32'h0000_0200, 0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule